// File: doc/BRIEF.md
# Dual-Mode Real-Time Counter Core

This core keeps time from a slow oscillator clock. A prescaler divides that clock into one-second ticks. On each tick the core advances the timekeeping state that the mode input selects. In calendar mode the state is a set of fields: seconds, minutes, hours, day of month, month, a year offset from 2000, weekday and week number. The day rolls over according to the month length and the leap-year rule. In binary mode the state is one 43-bit counter.

Both modes present their state on the same 43-bit count word. A programmable alarm register is compared against this word. The match output is high for as long as the two are equal. A synchronous load port overwrites the active mode's state. The only reset is an active-low power-on reset.

Top module: `rtc_core`

## Requirements
- R1: After power-on reset the calendar holds 00:00:00, day 1, month 1, year offset 0, weekday 1, week 1. The binary counter holds 0, the prescaler holds 0 and the alarm register holds all ones, so match is low.
- R2: While tick_en is high, the active state advances once every PRESC_DIV clocks, counted from reset or from the last load. While tick_en is low, the prescaler and all state hold.
- R3: Seconds and minutes count 0 to 59 and hours count 0 to 23. Each field wraps to 0 and carries into the next field.
- R4: After the hours wrap, the day advances. When the day equals the month's length, it returns to 1 and the month advances. Months 4, 6, 9 and 11 have 30 days, and every month other than February has 31.
- R5: February has 29 days when 2000+year is divisible by 4 and is either not divisible by 100 or divisible by 400. Otherwise it has 28, so offsets 100 and 200 give 28.
- R6: Month 12 wraps to 1 and advances the year. Year offset 255 wraps to 0.
- R7: Each day rollover advances the weekday, with 7 wrapping to 1. The week number advances only when the weekday wraps, with 52 wrapping to 1.
- R8: In binary mode the counter adds 1 per tick and wraps from 2^43-1 to 0.
- R9: cal_mode=1 selects calendar, cal_mode=0 selects binary. count_o shows the selected state. The state of the unselected mode holds its value untouched.
- R10: load_en writes load_val into the active mode's state only and clears the prescaler. While load_en is held, the load wins over any tick.
- R11: alarm_wr stores alarm_val on the next clock. match_o is high in the same cycle that count_o equals the stored alarm, in either mode.
- R12: In calendar mode the count word is laid out as week[42:37], weekday[36:34], year[33:26], month[25:22], day[21:17], hour[16:12], minute[11:6], second[5:0]. The load and alarm words use the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rtc | input | 1 | Oscillator clock for all state |
| por_n | input | 1 | Active-low power-on reset |
| cal_mode | input | 1 | 1 selects calendar, 0 selects binary |
| tick_en | input | 1 | Enables the one-second prescaler |
| load_en | input | 1 | Synchronous load of the active state |
| load_val | input | BIN_W | Value to load |
| alarm_wr | input | 1 | Stores alarm_val in the alarm register |
| alarm_val | input | BIN_W | Alarm compare value |
| count_o | output | BIN_W | Active count word |
| match_o | output | 1 | High while count equals alarm |

## Verification
A wrong carry or a wrong month-length decision shows up at count_o on the first tick after the boundary. The bench loads a value one second before each boundary so that any error appears within one prescaler period. A prescaler fault moves the tick edge by one or more clocks, and the bench samples exactly at the tick clock and one clock before it. A stale alarm register or a broken comparator shows up as match_o sitting high or low on the tick that reaches the alarm value, or on the tick after it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int CAL_W = 43;

   typedef struct packed {
      logic [5:0] week;
      logic [2:0] wday;
      logic [7:0] year;
      logic [3:0] mon;
      logic [4:0] day;
      logic [4:0] hour;
      logic [5:0] mins;
      logic [5:0] secs;
   } cal_t;

   localparam cal_t CAL_RST = '{week: 6'd1, wday: 3'd1, year: 8'd0, mon: 4'd1,
                                day: 5'd1, hour: 5'd0, mins: 6'd0, secs: 6'd0};

   function automatic logic is_leap(input logic [7:0] yoff);
      int unsigned y;
      y = 32'd2000 + {24'd0, yoff};
      return ((y % 4) == 0) && (((y % 100) != 0) || ((y % 400) == 0));
   endfunction

   function automatic logic [4:0] month_len(input logic [3:0] m, input logic [7:0] yoff);
      case (m)
         4'd2:                      return is_leap(yoff) ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
         default:                   return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   output logic tick
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] cnt_q;

   assign tick = en && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clr)      cnt_q <= '0;
      else if (tick)     cnt_q <= '0;
      else if (en)       cnt_q <= cnt_q + 1'b1;
   end

   AST_PRESC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   input  logic ld,
   input  cal_t ld_val,
   output cal_t q
);
   cal_t nxt;

   always_comb begin
      nxt = q;
      if (q.secs < 6'd59) nxt.secs = q.secs + 6'd1;
      else begin
         nxt.secs = '0;
         if (q.mins < 6'd59) nxt.mins = q.mins + 6'd1;
         else begin
            nxt.mins = '0;
            if (q.hour < 5'd23) nxt.hour = q.hour + 5'd1;
            else begin
               nxt.hour = '0;
               nxt.wday = (q.wday >= 3'd7) ? 3'd1 : q.wday + 3'd1;
               if (q.wday >= 3'd7)
                  nxt.week = (q.week >= 6'd52) ? 6'd1 : q.week + 6'd1;
               if (q.day < month_len(q.mon, q.year)) nxt.day = q.day + 5'd1;
               else begin
                  nxt.day = 5'd1;
                  if (q.mon < 4'd12) nxt.mon = q.mon + 4'd1;
                  else begin
                     nxt.mon  = 4'd1;
                     nxt.year = q.year + 8'd1;
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            q <= CAL_RST;
      else if (en && ld)     q <= ld_val;
      else if (en && tick)   q <= nxt;
   end

   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && !ld && q.secs == 6'd59) |=> (q.secs == 6'd0)); // R3
   AST_WEEK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && q.wday != 3'd7) |=> $stable(q.week)); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en || (!ld && !tick)) |=> $stable(q)); // R9

endmodule

// File: rtl/rtc_binary.sv
module rtc_binary #(
   parameter int W = 43
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         tick,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            q <= '0;
      else if (en && ld)     q <= ld_val;
      else if (en && tick)   q <= q + 1'b1;
   end

   AST_BIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && !ld) |=> (q == $past(q) + 1'b1)); // R8

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
   parameter int W         = 43,
   parameter bit MATCH_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wr_val,
   input  logic [W-1:0] cnt,
   output logic         match
);
   logic [W-1:0] alarm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   alarm_q <= '1;
      else if (wr)  alarm_q <= wr_val;
   end

   generate
      if (MATCH_REG) begin : g_reg
         logic match_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) match_q <= 1'b0;
            else        match_q <= (cnt == alarm_q);
         end
         assign match = match_q;
      end else begin : g_comb
         assign match = (cnt == alarm_q);
      end
   endgenerate

   AST_ALARM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (alarm_q == $past(wr_val))); // R11

endmodule

// File: rtl/rtc_core.sv
module rtc_core
   import rtc_pkg::*;
#(
   parameter int PRESC_DIV = 32768,
   parameter int BIN_W     = 43,
   parameter bit MATCH_REG = 1'b0
) (
   input  logic             clk_rtc,
   input  logic             por_n,
   input  logic             cal_mode,
   input  logic             tick_en,
   input  logic             load_en,
   input  logic [BIN_W-1:0] load_val,
   input  logic             alarm_wr,
   input  logic [BIN_W-1:0] alarm_val,
   output logic [BIN_W-1:0] count_o,
   output logic             match_o
);
   generate
      if (BIN_W != CAL_W) begin : g_bad_width
         $error("rtc_core: BIN_W must equal the calendar word width");
      end
      if (PRESC_DIV < 2) begin : g_bad_div
         $error("rtc_core: PRESC_DIV must be at least 2");
      end
   endgenerate

   logic             sec_tick;
   cal_t             cal_q;
   cal_t             cal_ld;
   logic [BIN_W-1:0] bin_q;

   assign cal_ld = load_val;

   rtc_prescaler #(.DIV(PRESC_DIV)) u_presc (
      .clk(clk_rtc), .rst_n(por_n), .en(tick_en), .clr(load_en), .tick(sec_tick)
   );

   rtc_calendar u_cal (
      .clk(clk_rtc), .rst_n(por_n), .en(cal_mode), .tick(sec_tick),
      .ld(load_en), .ld_val(cal_ld), .q(cal_q)
   );

   rtc_binary #(.W(BIN_W)) u_bin (
      .clk(clk_rtc), .rst_n(por_n), .en(!cal_mode), .tick(sec_tick),
      .ld(load_en), .ld_val(load_val), .q(bin_q)
   );

   assign count_o = cal_mode ? cal_q : bin_q;

   rtc_alarm #(.W(BIN_W), .MATCH_REG(MATCH_REG)) u_alarm (
      .clk(clk_rtc), .rst_n(por_n), .wr(alarm_wr), .wr_val(alarm_val),
      .cnt(count_o), .match(match_o)
   );

   AST_LOAD_WINS: assert property (@(posedge clk_rtc) disable iff (!por_n)
      load_en |=> (count_o == $past(load_val) || $past(cal_mode) != cal_mode)); // R10

endmodule

// File: tb/tb_rtc_core.sv
module tb_rtc_core;
   localparam int DIV = 4;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        cal_mode = 1'b1;
   logic        tick_en = 1'b0;
   logic        load_en = 1'b0;
   logic [42:0] load_val = '0;
   logic        alarm_wr = 1'b0;
   logic [42:0] alarm_val = '0;
   logic [42:0] count_o;
   logic        match_o;

   int total = 0;
   int failed = 0;

   always #4 clk = ~clk;

   rtc_core #(.PRESC_DIV(DIV), .BIN_W(43), .MATCH_REG(1'b0)) dut (
      .clk_rtc(clk), .por_n(por_n), .cal_mode(cal_mode), .tick_en(tick_en),
      .load_en(load_en), .load_val(load_val), .alarm_wr(alarm_wr),
      .alarm_val(alarm_val), .count_o(count_o), .match_o(match_o)
   );

   // R12 layout: week, weekday, year, month, day, hour, minute, second
   function automatic logic [42:0] cal(input int wk, input int wd, input int yr, input int mo,
                                       input int dy, input int hh, input int mm, input int ss);
      return {6'(wk), 3'(wd), 8'(yr), 4'(mo), 5'(dy), 5'(hh), 6'(mm), 6'(ss)};
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         failed++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic do_load(input logic [42:0] v);
      @(negedge clk); load_val = v; load_en = 1'b1;
      @(posedge clk);
      @(negedge clk); load_en = 1'b0;
   endtask

   task automatic wait_ticks(input int k);
      repeat (DIV * k) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic roll(input string tag, input logic [42:0] from, input logic [42:0] to);
      do_load(from);
      wait_ticks(1);
      chk(tag, 64'(count_o), 64'(to));
   endtask

   task automatic t_reset;
      repeat (3) @(posedge clk);
      @(negedge clk); por_n = 1'b1;
      @(negedge clk);
      chk("R1/R12 reset calendar word", 64'(count_o), 64'(cal(1,1,0,1,1,0,0,0)));
      chk("R1 reset match", 64'(match_o), 64'd0);
   endtask

   task automatic t_prescale;
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk("R2 hold while tick_en low", 64'(count_o), 64'(cal(1,1,0,1,1,0,0,0)));
      tick_en = 1'b1;
      repeat (DIV - 1) @(posedge clk);
      @(negedge clk);
      chk("R2 no tick one clock early", 64'(count_o), 64'(cal(1,1,0,1,1,0,0,0)));
      @(posedge clk); @(negedge clk);
      chk("R2 tick after divider", 64'(count_o), 64'(cal(1,1,0,1,1,0,0,1)));
      do_load(cal(9,2,7,3,5,8,8,8));
      tick_en = 1'b0;
      repeat (12) @(posedge clk);
      @(negedge clk);
      chk("R2 frozen with tick_en low", 64'(count_o), 64'(cal(9,2,7,3,5,8,8,8)));
      tick_en = 1'b1;
      wait_ticks(1);
      chk("R2 resumes", 64'(count_o), 64'(cal(9,2,7,3,5,8,8,9)));
   endtask

   task automatic t_time_carry;
      roll("R3 minute/hour carry", cal(9,2,7,3,5,13,59,59), cal(9,2,7,3,5,14,0,0));
      roll("R4/R7 30-day month", cal(20,6,9,4,30,23,59,59), cal(20,7,9,5,1,0,0,0));
      roll("R4 31-day month", cal(5,3,9,1,31,23,59,59), cal(5,4,9,2,1,0,0,0));
      roll("R4 mid month", cal(5,3,9,1,30,23,59,59), cal(5,4,9,1,31,0,0,0));
   endtask

   task automatic t_leap;
      roll("R5 2000 leap", cal(8,2,0,2,28,23,59,59), cal(8,3,0,2,29,0,0,0));
      roll("R5 Feb 29 end", cal(8,2,0,2,29,23,59,59), cal(8,3,0,3,1,0,0,0));
      roll("R5 2100 not leap", cal(8,2,100,2,28,23,59,59), cal(8,3,100,3,1,0,0,0));
      roll("R5 2004 leap", cal(8,2,4,2,28,23,59,59), cal(8,3,4,2,29,0,0,0));
      roll("R5 2001 not leap", cal(8,2,1,2,28,23,59,59), cal(8,3,1,3,1,0,0,0));
   endtask

   task automatic t_year;
      roll("R6/R7 year and week wrap", cal(52,7,255,12,31,23,59,59), cal(1,1,0,1,1,0,0,0));
      roll("R6/R7 new year, week held", cal(10,3,0,12,31,23,59,59), cal(10,4,1,1,1,0,0,0));
      roll("R7 week advance", cal(10,7,3,6,9,23,59,59), cal(11,1,3,6,10,0,0,0));
   endtask

   task automatic t_load_priority;
      @(negedge clk); load_val = cal(3,3,3,3,3,3,3,3); load_en = 1'b1;
      repeat (12) @(posedge clk);
      @(negedge clk);
      chk("R10 held load beats ticks", 64'(count_o), 64'(cal(3,3,3,3,3,3,3,3)));
      load_en = 1'b0;
      wait_ticks(1);
      chk("R10 count after load release", 64'(count_o), 64'(cal(3,3,3,3,3,3,3,4)));
   endtask

   task automatic t_binary;
      logic [42:0] saved;
      @(negedge clk);
      saved = count_o;
      cal_mode = 1'b0;
      #1;
      chk("R9 binary view idle at 0", 64'(count_o), 64'd0);
      do_load(43'd5);
      wait_ticks(3);
      chk("R8 binary count", 64'(count_o), 64'd8);
      do_load({42'h3FF_FFFF_FFFF, 1'b0});
      wait_ticks(1);
      chk("R8 binary max", 64'(count_o), 64'h7FF_FFFF_FFFF);
      wait_ticks(1);
      chk("R8 binary wrap", 64'(count_o), 64'd0);
      @(negedge clk); cal_mode = 1'b1;
      #1;
      chk("R9/R10 calendar untouched by binary run and load", 64'(count_o), 64'(saved));
   endtask

   task automatic t_alarm;
      @(negedge clk); cal_mode = 1'b0; alarm_wr = 1'b1; alarm_val = 43'd102;
      @(negedge clk); alarm_wr = 1'b0;
      do_load(43'd100);
      wait_ticks(1);
      chk("R11 binary before alarm", 64'(match_o), 64'd0);
      wait_ticks(1);
      chk("R11 binary at alarm", 64'(match_o), 64'd1);
      wait_ticks(1);
      chk("R11 binary past alarm", 64'(match_o), 64'd0);
      @(negedge clk); cal_mode = 1'b1; alarm_wr = 1'b1; alarm_val = cal(4,5,20,6,15,10,20,31);
      @(negedge clk); alarm_wr = 1'b0;
      do_load(cal(4,5,20,6,15,10,20,30));
      chk("R11 calendar before alarm", 64'(match_o), 64'd0);
      wait_ticks(1);
      chk("R11 calendar at alarm", 64'(match_o), 64'd1);
      wait_ticks(1);
      chk("R11 calendar past alarm", 64'(match_o), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failed++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      t_reset;
      t_prescale;
      t_time_carry;
      t_leap;
      t_year;
      t_load_priority;
      t_binary;
      t_alarm;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

endmodule